// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Interlock Controller

This block sits between a PWM source and the two gate drivers of a half bridge. It takes a high-side request and a low-side request and produces two gate-enable outputs. Each output may rise only after a programmable dead time has been counted out. The opposite output must also already be low before that count can start. Falling edges are not delayed. If both requests are high together, both outputs are held low.

Several conditions force both outputs low, whatever the requests are: a disable line, an input-side undervoltage flag, an output-side undervoltage flag, and a thermal shutdown. The thermal shutdown is derived from a digital temperature code and has hysteresis. The request, disable and undervoltage inputs each pass through a two-stage synchronizer. A three-bit status output shows which conditions are currently forcing the outputs low. Once a forcing condition clears, an output rises only after a full dead time counted from that moment.

With a 200 MHz clock, one count of the dead-time setting is 5 ns. The setting is clamped to between 10 and 500 cycles, which is 50 ns to 2500 ns.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: With a request held high, the other request low, the other output low and no forcing condition, the output rises on the (D+2)-th rising clock edge after the request changes. D is the effective dead time in cycles.
- R2: gate_hi and gate_lo are never both high in the same cycle.
- R3: While both requests are high, both outputs are low from the third clock edge onward.
- R4: An output that is high goes low on the third clock edge after its request falls, with no dead time added.
- R5: The effective dead time D equals dt_cnt clamped to the range 10 to 500 cycles. Settings below 10 act as 10, and settings above 500 act as 500.
- R6: On a hand-over from one request to the other, the newly enabled output rises exactly D cycles after the other output falls.
- R7: A request pulse shorter than D cycles produces no output pulse.
- R8: A high disable input forces both outputs low from the third edge. After disable is released, an output rises only after a full D count, on the (D+2)-th edge after the release.
- R9: A high uv_in or uv_out flag forces both outputs low in the same way as disable. After the flag clears, the outputs follow the requests again, subject to the full dead time.
- R10: temp_code is an unsigned value in °C with 1 °C per LSB. Thermal shutdown is entered when the code is 155 or more. It is left only when the code is below 125. While it is active, both outputs are low.
- R11: fault_st bit 0 is the synchronized disable and bit 1 is the synchronized OR of the two undervoltage flags; both appear two edges after their inputs change. Bit 2 is the thermal shutdown state, which is updated one edge after temp_code changes.
- R12: During and after reset, both outputs are low and fault_st is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (5 ns per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_hi | input | 1 | High-side request |
| req_lo | input | 1 | Low-side request |
| dis | input | 1 | Disable, forces both outputs low |
| uv_in | input | 1 | Input-side undervoltage flag |
| uv_out | input | 1 | Output-side undervoltage flag |
| temp_code | input | TEMP_W | Die temperature, °C, unsigned |
| dt_cnt | input | DT_W | Dead-time setting in clock cycles |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| fault_st | output | 3 | Forcing causes: {thermal, undervoltage, disable} |

## Verification
The risky coincidence is a dead-time count reaching its end in the same cycle as a forcing condition arrives or clears, or as the opposite request rises. In that cycle the interlock must win over the pending rise. The random phase provokes this by toggling requests, disable, undervoltage and a temperature code that wanders around both thresholds. It uses short dead-time settings, so counts often finish right at those edges. A cycle-level reference model in the bench is compared against both outputs and the status every cycle. The no-overlap and forced-low properties judge the same cycles independently.

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int DT_W    = 10,
  parameter int TEMP_W  = 8,
  parameter int DT_MIN  = 10,
  parameter int DT_MAX  = 500,
  parameter int TSD_ON  = 155,
  parameter int TSD_OFF = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_hi,
  input  logic              req_lo,
  input  logic              dis,
  input  logic              uv_in,
  input  logic              uv_out,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [DT_W-1:0]   dt_cnt,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic [2:0]        fault_st
);
  localparam int CW = $clog2(DT_MAX + 1);
  localparam int NS = 5;

  logic [NS-1:0] raw, s1, s2;
  logic          tsd_q;
  logic          kill;
  logic [1:0]    gate;
  logic [CW-1:0] dt_eff;

  assign raw = {uv_out, uv_in, dis, req_lo, req_hi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     tsd_q <= 1'b0;
    else if (tsd_q) tsd_q <= (temp_code >= TEMP_W'(TSD_OFF));
    else            tsd_q <= (temp_code >= TEMP_W'(TSD_ON));

  always_comb begin
    if (dt_cnt < DT_W'(DT_MIN))      dt_eff = CW'(DT_MIN);
    else if (dt_cnt > DT_W'(DT_MAX)) dt_eff = CW'(DT_MAX);
    else                             dt_eff = CW'(dt_cnt);
  end

  assign kill = s2[2] | s2[3] | s2[4] | tsd_q;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    localparam int O = 1 - g;
    logic          on_q;
    logic [CW-1:0] cnt_q;
    logic          ok;

    assign ok      = s2[g] & ~s2[O] & ~kill;
    assign gate[g] = on_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else if (!ok) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else if (!on_q && !gate[O]) begin
        if (cnt_q + CW'(1) >= dt_eff) begin
          on_q  <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
  end

  assign gate_hi  = gate[0];
  assign gate_lo  = gate[1];
  assign fault_st = {tsd_q, s2[3] | s2[4], s2[2]};
endmodule

// File: rtl/hb_deadtime_chk.sv
module hb_deadtime_chk #(
  parameter int TEMP_W  = 8,
  parameter int TSD_ON  = 155,
  parameter int TSD_OFF = 125
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_hi,
  input logic              req_lo,
  input logic              dis,
  input logic              uv_in,
  input logic              uv_out,
  input logic [TEMP_W-1:0] temp_code,
  input logic              gate_hi,
  input logic              gate_lo,
  input logic [2:0]        fault_st
);
  logic [2:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            age <= '0;
    else if (age != 3'd4)  age <= age + 3'd1;

  assign warm = (age == 3'd4);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R2

  AST_BOTH_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(req_hi, 3) && $past(req_lo, 3)) |-> (!gate_hi && !gate_lo)); // R3

  AST_FALL_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(req_hi, 3)) |-> !gate_hi); // R4

  AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(dis, 3)) |-> (!gate_hi && !gate_lo)); // R8

  AST_UV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ($past(uv_in, 3) || $past(uv_out, 3))) |-> (!gate_hi && !gate_lo)); // R9

  AST_TSD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(temp_code) >= TEMP_W'(TSD_ON)) |-> fault_st[2]); // R10

  AST_TSD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(fault_st[2]) && $past(temp_code) >= TEMP_W'(TSD_OFF)) |-> fault_st[2]); // R10

  AST_STATUS_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (fault_st[0] == $past(dis, 2))); // R11

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (!gate_hi && !gate_lo && fault_st == 3'b000)); // R12
endmodule

bind hb_deadtime_ctrl hb_deadtime_chk #(.TEMP_W(TEMP_W), .TSD_ON(TSD_ON), .TSD_OFF(TSD_OFF)) u_chk (.*);

// File: tb/sim_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module sim_hb_deadtime_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_hi = 0, req_lo = 0, dis = 0, uv_in = 0, uv_out = 0;
  logic [7:0] temp_code = 8'd40;
  logic [9:0] dt_cnt = 10'd10;
  logic       gate_hi, gate_lo;
  logic [2:0] fault_st;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hb_deadtime_ctrl u0 (.*);

  function automatic int dt_ref(input logic [9:0] v);
    if (v < 10)  return 10;
    if (v > 500) return 500;
    return int'(v);
  endfunction

  // reference model
  logic [4:0] m_s1, m_s2;
  logic       m_tsd;
  int         m_cnt [2];
  logic [1:0] m_g;
  logic       m_kill;
  logic [2:0] m_st;
  assign m_kill = m_s2[2] | m_s2[3] | m_s2[4] | m_tsd;
  assign m_st   = {m_tsd, m_s2[3] | m_s2[4], m_s2[2]};

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_tsd <= 0; m_g <= '0;
      m_cnt[0] <= 0; m_cnt[1] <= 0;
    end else begin
      m_s1  <= {uv_out, uv_in, dis, req_lo, req_hi};
      m_s2  <= m_s1;
      m_tsd <= m_tsd ? (temp_code >= 8'd125) : (temp_code >= 8'd155);
      for (int i = 0; i < 2; i++) begin
        if (!m_s2[i] || m_s2[1-i] || m_kill) begin
          m_cnt[i] <= 0; m_g[i] <= 1'b0;
        end else if (!m_g[0] && !m_g[1]) begin
          if (m_cnt[i] + 1 >= dt_ref(dt_cnt)) begin
            m_g[i] <= 1'b1; m_cnt[i] <= 0;
          end else m_cnt[i] <= m_cnt[i] + 1;
        end
      end
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk)
    if (rst_n && !done) begin
      chk({gate_lo, gate_hi} == m_g, "R1 R2 gates vs model", {gate_lo, gate_hi}, m_g);
      chk(fault_st == m_st, "R11 status vs model", fault_st, m_st);
      chk(!(gate_hi && gate_lo), "R2 overlap", 1, 0);
    end

  task automatic wait_for(input bit hi_side, input logic val, input int lim, output int k);
    k = 0;
    while (k < lim) begin
      @(negedge clk); k++;
      if ((hi_side ? gate_hi : gate_lo) == val) break;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rise_test(input int setting, input int expd, input string tag);
    int k;
    dt_cnt = 10'(setting);
    req_hi = 1;
    wait_for(1, 1, 700, k);
    chk(k == expd, tag, k, expd);
    req_hi = 0;
    wait_for(1, 0, 10, k);
    chk(k == 3, "R4 prompt fall", k, 3);
    idle(4);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k, k1, k2;
    void'($urandom(32'd2718));
    idle(4);
    chk(!gate_hi && !gate_lo, "R12 outputs in reset", {gate_lo, gate_hi}, 0);
    chk(fault_st == 3'b000, "R12 status in reset", fault_st, 0);
    rst_n = 1;
    idle(3);
    chk(!gate_hi && !gate_lo && fault_st == 0, "R12 after reset", {fault_st, gate_lo, gate_hi}, 0);

    rise_test(10, 12, "R1 rise dt=10");
    rise_test(37, 39, "R1 rise dt=37");
    rise_test(3, 12, "R5 clamp low");
    rise_test(900, 502, "R5 clamp high");

    // hand-over
    dt_cnt = 10'd20;
    req_hi = 1; wait_for(1, 1, 100, k);
    req_hi = 0; req_lo = 1;
    k1 = 0; k2 = 0;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (k1 == 0 && !gate_hi) k1 = i;
      if (gate_lo) begin k2 = i; break; end
    end
    chk(k2 - k1 == 20, "R6 hand-over gap", k2 - k1, 20);

    // both high
    req_hi = 1;
    idle(3);
    chk(!gate_hi && !gate_lo, "R3 both requests", {gate_lo, gate_hi}, 0);
    idle(30);
    chk(!gate_hi && !gate_lo, "R3 both requests held", {gate_lo, gate_hi}, 0);
    req_hi = 0; req_lo = 0; idle(4);

    // short pulse
    req_hi = 1; idle(15); req_hi = 0;
    k1 = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (gate_hi) k1 = 1; end
    chk(k1 == 0, "R7 short pulse", k1, 0);

    // disable
    req_hi = 1; wait_for(1, 1, 100, k);
    dis = 1; idle(3);
    chk(!gate_hi, "R8 disable forces low", gate_hi, 0);
    chk(fault_st == 3'b001, "R11 disable status", fault_st, 1);
    dis = 0; wait_for(1, 1, 100, k);
    chk(k == 22, "R8 rise after disable", k, 22);

    // undervoltage
    uv_out = 1; idle(3);
    chk(!gate_hi && fault_st == 3'b010, "R9 uv_out forces low", {fault_st, gate_hi}, 4);
    uv_out = 0; wait_for(1, 1, 100, k);
    chk(k == 22, "R9 rise after uv_out", k, 22);
    uv_in = 1; idle(3);
    chk(!gate_hi && fault_st == 3'b010, "R9 uv_in forces low", {fault_st, gate_hi}, 4);
    uv_in = 0; wait_for(1, 1, 100, k);
    chk(k == 22, "R9 rise after uv_in", k, 22);

    // thermal hysteresis
    temp_code = 8'd154; idle(3);
    chk(gate_hi && fault_st == 0, "R10 below entry", {fault_st, gate_hi}, 1);
    temp_code = 8'd155; idle(1);
    chk(fault_st == 3'b100, "R11 thermal status one edge", fault_st, 4);
    idle(1);
    chk(!gate_hi, "R10 shutdown low", gate_hi, 0);
    temp_code = 8'd125; idle(5);
    chk(fault_st == 3'b100 && !gate_hi, "R10 hold at 125", {fault_st, gate_hi}, 8);
    temp_code = 8'd124; wait_for(1, 1, 100, k);
    chk(k == 21, "R10 rise after exit", k, 21);
    req_hi = 0; temp_code = 8'd60; idle(4);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 11) == 0) req_hi = ~req_hi;
      if ($urandom_range(0, 11) == 0) req_lo = ~req_lo;
      if ($urandom_range(0, 199) == 0) dis = ~dis;
      if ($urandom_range(0, 299) == 0) uv_in = ~uv_in;
      if ($urandom_range(0, 299) == 0) uv_out = ~uv_out;
      if ($urandom_range(0, 7) == 0) temp_code = 8'($urandom_range(110, 170));
      if ($urandom_range(0, 499) == 0) dt_cnt = 10'($urandom_range(0, 24));
    end
    dis = 1; idle(4);
    chk(!gate_hi && !gate_lo, "R8 final disable", {gate_lo, gate_hi}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule